// File: doc/BRIEF.md
# Serial Planar Intra Predictor

This block produces the planar intra prediction of one square block of 8-bit samples, either 16x16 (luma) or 8x8 (chroma). A host first fills a small reference store, one sample per cycle, through an address/data write port. A start pulse then launches a scan that emits one 12-bit prediction per cycle in raster order. Each output carries a valid flag and its row and column. A single pulse marks the end of the scan.

All predictions share one weighted-sum datapath, which serves every position of the block in turn. The reference store keeps its contents after a scan finishes, so a block can be predicted again without reloading it. The size input is sampled together with the start pulse.

Top module: `planar_pred_serial`

## Requirements
- R1: During reset, and in the first cycle after it, `busy`, `pred_valid` and `done` are low.
- R2: A write with `ref_we` high stores `ref_data` at `ref_addr` (0..34) on the clock edge. Entries keep their values across scans until they are written again.
- R3: Reference layout: entry 1 holds the top-right sample and entry 2 the bottom-left sample. The top row occupies entries 3..3+N-1. The left column occupies entries N+3..2N+2, which is 19.. for N=16 and 11.. for N=8. Entry 0 is not read.
- R4: The sample at column x and row y equals (H + V + N) >> (log2(N)+1). Here H = (N-1-x)*left[y] + (x+1)*topright and V = (N-1-y)*top[x] + (y+1)*bottomleft. The sum is held in 13 bits without overflow.
- R5: `size_sel`=1 selects N=16 and `size_sel`=0 selects N=8. The value is taken in the cycle in which `start` is accepted.
- R6: Outputs come in raster order: row 0 first, left to right within each row. `pred_row` and `pred_col` give the position of each sample.
- R7: A start accepted at clock edge k makes `busy` high after edge k. The first sample (row 0, column 0) is valid after edge k+1. Exactly N*N valid cycles follow with no gaps.
- R8: `done` is high for exactly one cycle, the cycle right after the last valid sample. In that cycle `busy` and `pred_valid` are low.
- R9: A `start` pulse while `busy` is high is ignored. The scan in progress continues unchanged, and no second scan follows.
- R10: `pred_data` is 12 bits wide and its four upper bits are zero. With every reference at 255, every output is 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| size_sel | input | 1 | 1 = 16x16 block, 0 = 8x8 block |
| ref_we | input | 1 | Reference write enable |
| ref_addr | input | 6 | Reference entry index |
| ref_data | input | 8 | Reference sample to write |
| start | input | 1 | Start pulse for one scan |
| busy | output | 1 | Scan in progress |
| pred_valid | output | 1 | Prediction output valid |
| pred_data | output | 12 | Predicted sample |
| pred_row | output | 4 | Row of the current prediction |
| pred_col | output | 4 | Column of the current prediction |
| done | output | 1 | One-cycle pulse after the last sample |

## Verification
Flat references at mid-grey must give a flat output, which exposes errors in the rounding term and the shift. Ramped and hashed reference sets give each sample a distinct value, so they catch a swapped row and column, a wrong left-column base for each size, and mixed-up weights. A set that is zero except for the top-right sample isolates a single weight term. All-255 references test the widest intermediate sum. A repeat run without rewriting the store, and a start pulse injected in mid-scan, cover retention and the ignore-while-busy rule.

// File: rtl/planar_pkg.sv
// Package: shared sizes, reference layout indices and scan state type for
// the serial planar predictor. Assumes the small block is half the large one.
package planar_pkg;
    localparam int SAMP_W    = 8;
    localparam int MAX_LOG2  = 4;
    localparam int N_MAX     = 1 << MAX_LOG2;
    localparam int BUF_DEPTH = 2 * N_MAX + 3;
    localparam int ADDR_W    = $clog2(BUF_DEPTH);
    localparam int COORD_W   = MAX_LOG2;
    localparam int ACC_W     = SAMP_W + MAX_LOG2 + 1;
    localparam int OUT_W     = 12;
    localparam int TR_IDX    = 1;
    localparam int BL_IDX    = 2;
    localparam int TOP_BASE  = 3;

    typedef enum logic [1:0] {
        SC_IDLE  = 2'd0,
        SC_RUN   = 2'd1,
        SC_DRAIN = 2'd2
    } scan_state_t;
endpackage

// File: rtl/planar_ref_store.sv
// Reference store: DEPTH registers, written one entry per cycle, read
// combinationally through NRD independent ports. Assumes writes to an index
// at or beyond DEPTH are dropped and reads there return zero.
module planar_ref_store #(
    parameter int DEPTH = planar_pkg::BUF_DEPTH,
    parameter int AW    = planar_pkg::ADDR_W,
    parameter int DW    = planar_pkg::SAMP_W,
    parameter int NRD   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr [NRD],
    output logic [DW-1:0] rdata [NRD]
);
    logic [DW-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        // Entry i: cleared in reset, loaded when addressed by a write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[i] <= '0;
            else if (we && (waddr == AW'(i)))
                mem[i] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        // Read port p: guarded lookup of one entry.
        always_comb begin
            if (raddr[p] < AW'(DEPTH))
                rdata[p] = mem[raddr[p]];
            else
                rdata[p] = '0;
        end
    end
endmodule

// File: rtl/planar_scan_ctrl.sv
// Scan controller: accepts a start while idle, latches the size, walks row
// and column in raster order, drains the last output and pulses done.
// Assumes the datapath output register adds one cycle of latency.
module planar_scan_ctrl #(
    parameter int CW    = planar_pkg::COORD_W,
    parameter int N_BIG = planar_pkg::N_MAX
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          size_sel,
    output logic          run,
    output logic          big,
    output logic [CW-1:0] row,
    output logic [CW-1:0] col,
    output logic          busy,
    output logic          done
);
    import planar_pkg::*;

    localparam logic [CW-1:0] LAST_BIG   = CW'(N_BIG - 1);
    localparam logic [CW-1:0] LAST_SMALL = CW'(N_BIG / 2 - 1);

    scan_state_t   state_q;
    logic          big_q;
    logic [CW-1:0] row_q, col_q;
    logic          done_q;
    logic [CW-1:0] last_idx;
    logic          at_end;

    // Highest coordinate for the latched size and end-of-block detect.
    always_comb begin
        last_idx = big_q ? LAST_BIG : LAST_SMALL;
        at_end   = (row_q == last_idx) && (col_q == last_idx);
    end

    // State, size latch and raster counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SC_IDLE;
            big_q   <= 1'b0;
            row_q   <= '0;
            col_q   <= '0;
        end else begin
            case (state_q)
                SC_IDLE: begin
                    if (start) begin
                        state_q <= SC_RUN;
                        big_q   <= size_sel;
                        row_q   <= '0;
                        col_q   <= '0;
                    end
                end
                SC_RUN: begin
                    if (at_end) begin
                        state_q <= SC_DRAIN;
                    end else if (col_q == last_idx) begin
                        col_q <= '0;
                        row_q <= row_q + 1'b1;
                    end else begin
                        col_q <= col_q + 1'b1;
                    end
                end
                SC_DRAIN: state_q <= SC_IDLE;
                default:  state_q <= SC_IDLE;
            endcase
        end
    end

    // Done pulse: one cycle after the drain cycle carrying the last sample.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_q <= 1'b0;
        else
            done_q <= (state_q == SC_DRAIN);
    end

    assign run  = (state_q == SC_RUN);
    assign busy = (state_q != SC_IDLE);
    assign big  = big_q;
    assign row  = row_q;
    assign col  = col_q;
    assign done = done_q;
endmodule

// File: rtl/planar_weight_mac.sv
// Shared weighted-sum unit: forms the four distance-weighted products of
// one position, adds the rounding term, shifts and registers the result with
// its coordinates. Assumes the inputs are stable for the cycle in_valid is high.
module planar_weight_mac #(
    parameter int DW    = planar_pkg::SAMP_W,
    parameter int CW    = planar_pkg::COORD_W,
    parameter int AW_   = planar_pkg::ACC_W,
    parameter int OW    = planar_pkg::OUT_W,
    parameter int LOG2B = planar_pkg::MAX_LOG2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          big,
    input  logic [CW-1:0] row,
    input  logic [CW-1:0] col,
    input  logic [DW-1:0] left_s,
    input  logic [DW-1:0] top_s,
    input  logic [DW-1:0] tr_s,
    input  logic [DW-1:0] bl_s,
    output logic          out_valid,
    output logic [OW-1:0] out_data,
    output logic [CW-1:0] out_row,
    output logic [CW-1:0] out_col
);
    localparam int NBIG = 1 << LOG2B;

    logic [AW_-1:0] n_val;
    logic [AW_-1:0] w_left, w_tr, w_top, w_bl;
    logic [AW_-1:0] acc;
    logic [AW_-1:0] shifted;

    // Weights from position and size, then the rounded planar sum.
    always_comb begin
        n_val   = big ? AW_'(NBIG) : AW_'(NBIG / 2);
        w_left  = n_val - AW_'(1) - AW_'(col);
        w_tr    = AW_'(col) + AW_'(1);
        w_top   = n_val - AW_'(1) - AW_'(row);
        w_bl    = AW_'(row) + AW_'(1);
        acc     = w_left * AW_'(left_s) + w_tr * AW_'(tr_s)
                + w_top * AW_'(top_s) + w_bl * AW_'(bl_s) + n_val;
        shifted = big ? (acc >> (LOG2B + 1)) : (acc >> LOG2B);
    end

    // Output register: prediction, valid flag and coordinates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_row   <= '0;
            out_col   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= OW'(shifted);
                out_row  <= row;
                out_col  <= col;
            end
        end
    end
endmodule

// File: rtl/planar_pred_serial.sv
// Top: serial planar intra predictor. The host loads the reference store,
// pulses start, and receives one prediction per cycle in raster order.
// Assumes the store is not rewritten while a scan is running.
module planar_pred_serial #(
    parameter int DW  = planar_pkg::SAMP_W,
    parameter int AW  = planar_pkg::ADDR_W,
    parameter int CW  = planar_pkg::COORD_W,
    parameter int OW  = planar_pkg::OUT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          size_sel,
    input  logic          ref_we,
    input  logic [AW-1:0] ref_addr,
    input  logic [DW-1:0] ref_data,
    input  logic          start,
    output logic          busy,
    output logic          pred_valid,
    output logic [OW-1:0] pred_data,
    output logic [CW-1:0] pred_row,
    output logic [CW-1:0] pred_col,
    output logic          done
);
    import planar_pkg::*;

    localparam int NRD    = 4;
    localparam int P_TR   = 0;
    localparam int P_BL   = 1;
    localparam int P_TOP  = 2;
    localparam int P_LEFT = 3;

    logic          run, big;
    logic [CW-1:0] row, col;
    logic [AW-1:0] raddr [NRD];
    logic [DW-1:0] rdata [NRD];

    // Read addresses: fixed corners, top by column, left by row and size.
    always_comb begin
        raddr[P_TR]   = AW'(TR_IDX);
        raddr[P_BL]   = AW'(BL_IDX);
        raddr[P_TOP]  = AW'(TOP_BASE) + AW'(col);
        raddr[P_LEFT] = (big ? AW'(N_MAX) : AW'(N_MAX / 2)) + AW'(TOP_BASE) + AW'(row);
    end

    planar_ref_store #(
        .DEPTH(BUF_DEPTH), .AW(AW), .DW(DW), .NRD(NRD)
    ) i_store (
        .clk(clk), .rst_n(rst_n),
        .we(ref_we), .waddr(ref_addr), .wdata(ref_data),
        .raddr(raddr), .rdata(rdata)
    );

    planar_scan_ctrl #(
        .CW(CW), .N_BIG(N_MAX)
    ) i_ctrl (
        .clk(clk), .rst_n(rst_n),
        .start(start), .size_sel(size_sel),
        .run(run), .big(big), .row(row), .col(col),
        .busy(busy), .done(done)
    );

    planar_weight_mac #(
        .DW(DW), .CW(CW), .AW_(ACC_W), .OW(OW), .LOG2B(MAX_LOG2)
    ) i_mac (
        .clk(clk), .rst_n(rst_n),
        .in_valid(run), .big(big), .row(row), .col(col),
        .left_s(rdata[P_LEFT]), .top_s(rdata[P_TOP]),
        .tr_s(rdata[P_TR]), .bl_s(rdata[P_BL]),
        .out_valid(pred_valid), .out_data(pred_data),
        .out_row(pred_row), .out_col(pred_col)
    );
endmodule

// File: rtl/planar_pred_chk.sv
// Checker for the serial planar predictor, bound to the top module.
// Observes ports only.
module planar_pred_chk #(
    parameter int OW = planar_pkg::OUT_W,
    parameter int CW = planar_pkg::COORD_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          pred_valid,
    input logic [OW-1:0] pred_data,
    input logic [CW-1:0] pred_row,
    input logic [CW-1:0] pred_col,
    input logic          done
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && !pred_valid && !done));

    // R6
    raster_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid && $past(pred_valid)) |->
            ((pred_row == $past(pred_row) && pred_col == $past(pred_col) + 1'b1) ||
             (pred_col == '0 && pred_row == $past(pred_row) + 1'b1)));

    // R7
    first_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> (pred_valid && pred_row == '0 && pred_col == '0));

    // R8
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pred_valid) |-> (done && !busy));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

    // R10
    out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid |-> (pred_data[OW-1:8] == '0));
endmodule

bind planar_pred_serial planar_pred_chk #(.OW(OW), .CW(CW)) i_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .pred_valid(pred_valid), .pred_data(pred_data),
    .pred_row(pred_row), .pred_col(pred_col), .done(done)
);

// File: tb/test_planar_pred_serial.sv
`timescale 1ns/1ps
module test_planar_pred_serial;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        size_sel = 1'b0;
    logic        ref_we = 1'b0;
    logic [5:0]  ref_addr = '0;
    logic [7:0]  ref_data = '0;
    logic        start = 1'b0;
    logic        busy, pred_valid, done;
    logic [11:0] pred_data;
    logic [3:0]  pred_row, pred_col;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int refs [35];

    always #2.5 clk = ~clk;

    planar_pred_serial i_planar_pred_serial (
        .clk(clk), .rst_n(rst_n), .size_sel(size_sel),
        .ref_we(ref_we), .ref_addr(ref_addr), .ref_data(ref_data),
        .start(start), .busy(busy), .pred_valid(pred_valid),
        .pred_data(pred_data), .pred_row(pred_row), .pred_col(pred_col),
        .done(done)
    );

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: an overlong run is one failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cyc);
            finish_run();
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int model(input bit big, input int r, input int c);
        int n, lg, h, v;
        n  = big ? 16 : 8;
        lg = big ? 4 : 3;
        h  = (n - 1 - c) * refs[n + 3 + r] + (c + 1) * refs[1];
        v  = (n - 1 - r) * refs[3 + c] + (r + 1) * refs[2];
        return (h + v + n) >> (lg + 1);
    endfunction

    task automatic wr(input int a, input int d);
        @(negedge clk);
        ref_we = 1'b1; ref_addr = 6'(a); ref_data = 8'(d);
        refs[a] = d;
        @(negedge clk);
        ref_we = 1'b0;
    endtask

    // One scan: checks latency, order, values, done timing; optional mid-scan start.
    task automatic run_scan(input bit big, input int poke_at, input string tag);
        int n, idx, waited;
        bit poked;
        n = big ? 16 : 8;
        idx = 0; waited = 0; poked = 0;
        @(negedge clk);
        size_sel = big; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy && !pred_valid, {tag, " R7 busy after accept"}, int'(busy), 1);
        while (idx < n * n && waited < 1000) begin
            @(negedge clk);
            waited++;
            if (start) start = 1'b0;
            if (pred_valid) begin
                if (idx == 0) check(waited == 1, {tag, " R7 first latency"}, waited, 1);
                check(pred_row == 4'(idx / n) && pred_col == 4'(idx % n),
                      {tag, " R6 coordinates"}, int'(pred_row) * 16 + int'(pred_col),
                      (idx / n) * 16 + (idx % n));
                check(int'(pred_data) == model(big, idx / n, idx % n),
                      {tag, " R4 value"}, int'(pred_data), model(big, idx / n, idx % n));
                idx++;
                if (idx == poke_at && !poked) begin
                    start = 1'b1; poked = 1;
                end
            end else if (idx > 0) begin
                check(0, {tag, " R7 gap in output"}, idx, n * n);
                idx = n * n;
            end
        end
        check(idx == n * n, {tag, " R7 sample count"}, idx, n * n);
        @(negedge clk);
        check(done && !busy && !pred_valid, {tag, " R8 done after last"}, int'(done), 1);
        @(negedge clk);
        check(!done && !busy && !pred_valid, {tag, " R8/R9 idle afterwards"},
              int'(done) + int'(busy) + int'(pred_valid), 0);
    endtask

    task automatic t_reset();
        check(!busy && !pred_valid && !done, "R1 reset outputs",
              int'(busy) + int'(pred_valid) + int'(done), 0);
    endtask

    task automatic t_flat8();
        for (int a = 0; a < 19; a++) wr(a, 8'h80);
        run_scan(1'b0, -1, "flat8 R5");
    endtask

    task automatic t_ramp16_retain();
        for (int a = 0; a < 35; a++) wr(a, (a * 7 + 20) % 256);
        run_scan(1'b1, -1, "ramp16 R3");
        run_scan(1'b1, -1, "ramp16 rerun R2");
    endtask

    task automatic t_hash8();
        for (int a = 0; a < 35; a++) wr(a, (a * 37 + 11) % 256);
        run_scan(1'b0, -1, "hash8 R3 R5");
    endtask

    task automatic t_corner16();
        for (int a = 0; a < 35; a++) wr(a, (a == 1) ? 255 : 0);
        run_scan(1'b1, -1, "topright16 R4");
    endtask

    task automatic t_max16();
        for (int a = 0; a < 35; a++) wr(a, 255);
        run_scan(1'b1, -1, "max16 R10");
        check(int'(pred_data) == 255, "R10 saturated value held", int'(pred_data), 255);
    endtask

    task automatic t_busy_start();
        for (int a = 0; a < 35; a++) wr(a, (a * 13 + 5) % 256);
        run_scan(1'b0, 20, "busystart8 R9");
    endtask

    initial begin
        for (int a = 0; a < 35; a++) refs[a] = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_flat8();
        t_ramp16_retain();
        t_hash8();
        t_corner16();
        t_max16();
        t_busy_start();
        finish_run();
    end
endmodule